// File: doc/BRIEF.md
# Breaker Position Supervisor

This block watches a point-of-connection breaker and checks that its auxiliary contacts follow the last command given to it. The command is a single level: high means "be closed" and low means "be open". A normally-open and a normally-closed auxiliary contact, both already debounced, report where the breaker actually sits. A free-running millisecond tick paces the supervision window. When the contacts disagree with the command for longer than the configured window, the block latches a mechanical fault and names its type. It raises the auto-close inhibit output so that no automatic close is retried, and it pulses an event strobe once for the new fault.

Fault types are failed close, failed open, welded contact, feedback wiring fault and repeated close failure. A remote reset may clear a single failed close so that a new attempt can be made. Every other fault, and any run of consecutive failed closes that reaches the limit, stays latched until a local reset. The coil drive itself lies outside this block.

All pins are plain control and status levels. No data stream crosses the boundary, so there is no valid/ready handshake. The event strobe is a one-cycle pulse that nothing can hold back, and the fault code stays on its output for as long as the fault is latched.

Top module: `brk_pos_supervisor`

## Requirements
- R1: After reset the fault code is 0 (none), auto-close inhibit is low and the event strobe is low.
- R2: Contacts read closed when the normally-open input is 1 and the normally-closed input is 0. They read open when the normally-open input is 0 and the normally-closed input is 1. A mismatch is declared on the (W+1)-th millisecond tick of an unbroken mismatch, where W is the window input. A mismatch that ends sooner latches nothing, and any change of the condition restarts the count.
- R3: Close command (cmd_close=1) with contacts reading open for the window latches fault code 1 (failed close).
- R4: Open command (cmd_close=0) with contacts reading closed for the window latches code 2 (failed open). If that condition then lasts one further full window (W+1 more ticks), the code becomes 3 (welded contact).
- R5: Both contact inputs equal (both 1 or both 0) for the window latches code 4 (wiring fault), whatever the command.
- R6: The event strobe is high for exactly one cycle, in the cycle in which the fault code takes a new nonzero value. This includes the change from 2 to 3.
- R7: Auto-close inhibit is high exactly while the fault code is nonzero. While a fault is latched, no other fault replaces it; the only exception is the change from 2 to 3.
- R8: Consecutive failed close detections are counted. The detection that brings the count to 3 latches code 5 (repeated close failure) instead of code 1.
- R9: The consecutive-failure count clears whenever the close command is present and the contacts read closed.
- R10: Remote reset clears code 1 only. For codes 2, 3, 4 and 5 it has no effect.
- R11: Local reset clears any fault code and the consecutive-failure count, and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cfg_window | input | WIN_W | Mismatch window W, in ticks |
| cmd_close | input | 1 | Last issued command: 1 close, 0 open |
| aux_no | input | 1 | Debounced normally-open auxiliary contact |
| aux_nc | input | 1 | Debounced normally-closed auxiliary contact |
| remote_reset | input | 1 | Remote reset request (clears failed close only) |
| local_reset | input | 1 | Local reset (clears every fault) |
| fault_code | output | 3 | 0 none, 1 failed close, 2 failed open, 3 welded, 4 wiring, 5 repeated |
| auto_close_inhibit | output | 1 | Blocks automatic close attempts |
| fault_evt | output | 1 | One-cycle strobe when a new fault latches |

## Verification
The assertions check on every cycle that a local reset always returns the code to none, that the code only changes together with an event or a reset, and that events carry a nonzero code. They also check that a welded code is only reached from failed open, and that the terminal fault codes ignore everything except a local reset. The exact tick count of the window, the separation of the fault types and the consecutive-failure counting are shown by the bench scenarios. Those scenarios also cover the clearing of the count on a good close and the selective effect of remote reset, together with randomized windows and mismatch durations on both sides of the boundary.

// File: rtl/brk_sup_pkg.sv
package brk_sup_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_CLOSE  = 3'd1,
    FLT_OPEN   = 3'd2,
    FLT_WELD   = 3'd3,
    FLT_WIRE   = 3'd4,
    FLT_REPEAT = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    COND_OK       = 2'd0,
    COND_CLOSE_MM = 2'd1,
    COND_OPEN_MM  = 2'd2,
    COND_WIRE     = 2'd3
  } cond_e;
endpackage

// File: rtl/brk_contact_classify.sv
module brk_contact_classify
  import brk_sup_pkg::*;
(
  input  logic  cmd_close,
  input  logic  aux_no,
  input  logic  aux_nc,
  output cond_e cond,
  output logic  close_good
);
  logic reads_closed;
  logic reads_open;

  always_comb begin
    reads_closed = aux_no & ~aux_nc;
    reads_open   = ~aux_no & aux_nc;
    if (!(reads_closed || reads_open)) begin
      cond = COND_WIRE;
    end else if (cmd_close && reads_open) begin
      cond = COND_CLOSE_MM;
    end else if (!cmd_close && reads_closed) begin
      cond = COND_OPEN_MM;
    end else begin
      cond = COND_OK;
    end
    close_good = cmd_close & reads_closed;
  end
endmodule

// File: rtl/brk_window_timer.sv
module brk_window_timer
  import brk_sup_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] window,
  input  cond_e            cond,
  input  logic             clear,
  output logic             expire
);
  logic [WIN_W-1:0] elapsed;
  cond_e            cond_q;
  logic             cond_changed;

  assign cond_changed = (cond != cond_q);
  assign expire = ms_tick && !clear && !cond_changed &&
                  (cond != COND_OK) && (elapsed == window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      cond_q  <= COND_OK;
    end else begin
      cond_q <= cond;
      if (clear || cond_changed || cond == COND_OK) begin
        elapsed <= '0;
      end else if (expire) begin
        elapsed <= '0;
      end else if (ms_tick) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brk_fault_latch.sv
module brk_fault_latch
  import brk_sup_pkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cond_e  cond,
  input  logic   expire,
  input  logic   close_good,
  input  logic   remote_reset,
  input  logic   local_reset,
  output fault_e code,
  output logic   evt,
  output logic   clear
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAIL_LIMIT);

  logic [CNT_W-1:0] fails;
  logic [CNT_W-1:0] fails_inc;
  logic             remote_ok;

  assign fails_inc = fails + 1'b1;
  assign remote_ok = remote_reset && (code == FLT_CLOSE);
  assign clear     = local_reset || remote_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= FLT_NONE;
      fails <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (local_reset) begin
        code  <= FLT_NONE;
        fails <= '0;
      end else if (remote_ok) begin
        code <= FLT_NONE;
      end else if (expire) begin
        if (code == FLT_NONE) begin
          evt <= 1'b1;
          unique case (cond)
            COND_CLOSE_MM: begin
              fails <= fails_inc;
              code  <= (fails_inc >= LIMIT_V) ? FLT_REPEAT : FLT_CLOSE;
            end
            COND_OPEN_MM: code <= FLT_OPEN;
            COND_WIRE:    code <= FLT_WIRE;
            default:      evt  <= 1'b0;
          endcase
        end else if (code == FLT_OPEN && cond == COND_OPEN_MM) begin
          code <= FLT_WELD;
          evt  <= 1'b1;
        end
      end else if (close_good) begin
        fails <= '0;
      end
    end
  end
endmodule

// File: rtl/brk_pos_supervisor.sv
module brk_pos_supervisor
  import brk_sup_pkg::*;
#(
  parameter int WIN_W      = 12,
  parameter int FAIL_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic             cmd_close,
  input  logic             aux_no,
  input  logic             aux_nc,
  input  logic             remote_reset,
  input  logic             local_reset,
  output logic [2:0]       fault_code,
  output logic             auto_close_inhibit,
  output logic             fault_evt
);
  cond_e  cond;
  logic   close_good;
  logic   expire;
  logic   clear;
  fault_e code;

  brk_contact_classify u_classify (
    .cmd_close  (cmd_close),
    .aux_no     (aux_no),
    .aux_nc     (aux_nc),
    .cond       (cond),
    .close_good (close_good)
  );

  brk_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .window  (cfg_window),
    .cond    (cond),
    .clear   (clear),
    .expire  (expire)
  );

  brk_fault_latch #(.FAIL_LIMIT(FAIL_LIMIT)) u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond         (cond),
    .expire       (expire),
    .close_good   (close_good),
    .remote_reset (remote_reset),
    .local_reset  (local_reset),
    .code         (code),
    .evt          (fault_evt),
    .clear        (clear)
  );

  assign fault_code         = code;
  assign auto_close_inhibit = (code != FLT_NONE);
endmodule

// File: rtl/brk_pos_supervisor_chk.sv
module brk_pos_supervisor_chk
  import brk_sup_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       remote_reset,
  input logic       local_reset,
  input logic [2:0] fault_code,
  input logic       auto_close_inhibit,
  input logic       fault_evt
);
  assert_local_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    local_reset |=> (fault_code == FLT_NONE && !auto_close_inhibit));

  assert_evt_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (fault_code != FLT_NONE && auto_close_inhibit));

  assert_code_moves_only_on_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_reset && !remote_reset) |=> (fault_evt || $stable(fault_code)));

  assert_weld_from_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && fault_code == FLT_WELD) |-> $past(fault_code) == FLT_OPEN);

  assert_terminal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_code == FLT_WELD || fault_code == FLT_WIRE || fault_code == FLT_REPEAT)
      && !local_reset) |=> $stable(fault_code));

  assert_no_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != FLT_NONE && fault_code != FLT_OPEN && !local_reset && !remote_reset)
      |=> !fault_evt);
endmodule

bind brk_pos_supervisor brk_pos_supervisor_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .remote_reset       (remote_reset),
  .local_reset        (local_reset),
  .fault_code         (fault_code),
  .auto_close_inhibit (auto_close_inhibit),
  .fault_evt          (fault_evt)
);

// File: tb/brk_pos_supervisor_tb.sv
module brk_pos_supervisor_tb;
  localparam int WIN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ms_tick = 1'b0;
  logic [WIN_W-1:0] cfg_window = '0;
  logic             cmd_close = 1'b0;
  logic             aux_no = 1'b0;
  logic             aux_nc = 1'b1;
  logic             remote_reset = 1'b0;
  logic             local_reset = 1'b0;
  logic [2:0]       fault_code;
  logic             auto_close_inhibit;
  logic             fault_evt;

  int checks = 0;
  int errors = 0;
  int evt_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brk_pos_supervisor #(.WIN_W(WIN_W), .FAIL_LIMIT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_window(cfg_window),
    .cmd_close(cmd_close), .aux_no(aux_no), .aux_nc(aux_nc),
    .remote_reset(remote_reset), .local_reset(local_reset),
    .fault_code(fault_code), .auto_close_inhibit(auto_close_inhibit),
    .fault_evt(fault_evt)
  );

  always @(negedge clk) if (rst_n && fault_evt) evt_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_code(input string req, input int exp);
    check(req, fault_code, exp);
    check({req, " inhibit"}, auto_close_inhibit, exp != 0);
  endtask

  // kind: 0 ok(close+closed), 1 close mismatch, 2 open mismatch, 3 wiring
  task automatic set_cond(input int kind);
    @(negedge clk);
    case (kind)
      1: begin cmd_close = 1; aux_no = 0; aux_nc = 1; end
      2: begin cmd_close = 0; aux_no = 1; aux_nc = 0; end
      3: begin cmd_close = $urandom_range(0, 1); aux_no = 1; aux_nc = 1; end
      default: begin cmd_close = 1; aux_no = 1; aux_nc = 0; end
    endcase
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1;
      @(negedge clk);
      ms_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_remote();
    remote_reset = 1; @(negedge clk); remote_reset = 0; @(negedge clk);
  endtask

  task automatic pulse_local();
    local_reset = 1; @(negedge clk); local_reset = 0; @(negedge clk);
  endtask

  function automatic int exp_code(input int kind, input int n, input int w);
    case (kind)
      1: return (n > w) ? 1 : 0;
      2: return (n >= 2 * (w + 1)) ? 3 : ((n > w) ? 2 : 0);
      3: return (n > w) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check_code("R1 reset code", 0);
    check("R1 reset evt", fault_evt, 0);
    rst_n = 1;
    @(negedge clk);
    check_code("R1 after release", 0);

    cfg_window = 3;
    // R2 boundary and R3 failed close, R6 event
    set_cond(1);
    e0 = evt_seen;
    ticks(3);
    check_code("R2 window not yet exceeded", 0);
    ticks(1);
    check_code("R3 failed close", 1);
    check("R6 one event", evt_seen - e0, 1);
    // R10 remote reset clears failed close
    pulse_remote();
    check_code("R10 remote clears failed close", 0);
    // R9 good close clears count (count was 1)
    set_cond(0);
    // R2 interrupted mismatch raises nothing
    set_cond(2);
    ticks(2);
    set_cond(0);
    ticks(5);
    check_code("R2 interrupted mismatch", 0);

    // R4 failed open then welded
    set_cond(2);
    e0 = evt_seen;
    ticks(4);
    check_code("R4 failed open", 2);
    pulse_remote();
    check_code("R10 remote ignored for failed open", 2);
    ticks(3);
    check_code("R4 not yet welded", 2);
    ticks(1);
    check_code("R4 welded", 3);
    check("R6 two events open+weld", evt_seen - e0, 2);
    pulse_remote();
    check_code("R10 remote ignored for welded", 3);
    e0 = evt_seen;
    set_cond(3);
    ticks(10);
    check_code("R7 no replacement by wiring", 3);
    check("R7 no event while latched", evt_seen - e0, 0);
    pulse_local();
    check_code("R11 local clears welded", 0);

    // R5 wiring
    ticks(3);
    check_code("R5 wiring below window", 0);
    ticks(1);
    check_code("R5 wiring fault", 4);
    pulse_remote();
    check_code("R10 remote ignored for wiring", 4);
    set_cond(0);
    pulse_local();
    check_code("R11 local clears wiring", 0);

    // R8 repeated failed closes
    set_cond(1);
    ticks(4); check_code("R8 first failure", 1); pulse_remote();
    ticks(4); check_code("R8 second failure", 1); pulse_remote();
    ticks(4); check_code("R8 third failure repeated", 5);
    pulse_remote();
    check_code("R10 remote ignored for repeated", 5);
    pulse_local();
    check_code("R11 local clears repeated", 0);

    // R9 good close clears count
    ticks(4); check_code("R9 fail one", 1); pulse_remote();
    ticks(4); check_code("R9 fail two", 1); pulse_remote();
    set_cond(0);
    set_cond(1);
    ticks(4); check_code("R9 count cleared by good close", 1);
    pulse_remote();
    // R11 local reset also clears count
    ticks(4); check_code("R11 fail before local", 1);
    pulse_local();
    ticks(4); check_code("R11 fail after local", 1);
    ticks(4); pulse_remote();
    ticks(4); check_code("R11 count restarted", 1);
    set_cond(0);
    pulse_local();

    // constrained random windows and durations
    for (int it = 0; it < 40; it++) begin
      int w, k, n;
      w = $urandom_range(0, 6);
      k = $urandom_range(0, 3);
      n = $urandom_range(0, 2 * w + 4);
      cfg_window = WIN_W'(w);
      set_cond(0);
      pulse_local();
      set_cond(k);
      ticks(n);
      check_code($sformatf("R2 random k=%0d w=%0d n=%0d", k, w, n), exp_code(k, n, w));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule